// File: doc/BRIEF.md
# Barrel Shift Unit with Split Immediate Amount

This block is the shift stage of a 32-bit integer datapath. Each clock it takes an operand and a shift amount and produces a logical left, logical right or arithmetic right shift of that operand, together with new negative, zero and carry flags. The overflow flag is not affected by shifting; its incoming value is passed to the output unchanged.

The shift amount comes from one of three sources. It can be the low five bits of a register operand. It can be a 4-bit immediate, covering 0 to 15. It can also be that same immediate with 16 added, covering 16 to 31. The offset form exists because a 4-bit immediate cannot reach the upper half of the shift range on its own. Carry holds the last bit pushed out of the operand. A zero amount leaves the operand unchanged and clears carry. The result and all four flags are registered, so they appear one clock after the inputs. The block accepts a new shift on every clock.

There is no control sequencing. The house-style state register is reduced to the output register stage, with one process for that register and combinational processes for amount selection, shifting and flags.

Top module: `shf_unit`

## Requirements
- R1: With kind code 2'b00 (logical left), the result is the operand shifted toward bit 31 by the selected amount, with zeros entering at bit 0.
- R2: With kind code 2'b01 (logical right), the result is the operand shifted toward bit 0 by the selected amount, with zeros entering at bit 31.
- R3: With kind code 2'b10 (arithmetic right), the vacated upper bits are filled with copies of operand bit 31. Kind code 2'b11 behaves exactly like logical left.
- R4: With source code 2'b00 or 2'b11, the amount is bits 4:0 of the amount register input, and bits 31:5 of that input have no effect.
- R5: With source code 2'b01, the amount is the 4-bit immediate (0 to 15).
- R6: With source code 2'b10, the amount is the 4-bit immediate plus 16 (16 to 31).
- R7: Carry is the last bit shifted out of the operand: bit 32-n for a left shift and bit n-1 for a right shift. A zero amount passes the operand through unchanged and clears carry.
- R8: Negative equals result bit 31. Zero is 1 exactly when all 32 result bits are 0.
- R9: The overflow output equals the overflow input of the previous cycle, whatever shift is performed.
- R10: The result and flags are registered and appear on the first rising clock edge after the inputs. While reset is active, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_i | input | 32 | Value to be shifted |
| amt_reg_i | input | 32 | Register-sourced shift amount (low 5 bits used) |
| imm_i | input | 4 | Immediate shift amount |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 left |
| src_i | input | 2 | Amount source: 00 register, 01 immediate, 10 immediate+16, 11 register |
| v_i | input | 1 | Incoming overflow flag |
| res_o | output | 32 | Shifted result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag (passed through) |
| c_o | output | 1 | Carry flag |

## Verification
The only internal state is the output register, so any fault in it appears at the ports on the very next cycle. The bench compares every output on every clock against a bit-serial reference model. A wrong amount selection, for example a missing +16 offset or register bits above bit 4 leaking into the amount, shows up as a result shifted by the wrong distance and as a carry taken from the wrong bit. A wrong fill policy shows up in the upper result bits of right shifts of negative operands. Flag faults show up as a mismatch against the result on the same cycle.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ALT = 2'b11
    } shf_kind_e;

    typedef enum logic [1:0] {
        SHS_REG  = 2'b00,
        SHS_IMM  = 2'b01,
        SHS_IMMH = 2'b10,
        SHS_ALT  = 2'b11
    } shf_src_e;
endpackage

// File: rtl/shf_amt_sel.sv
module shf_amt_sel #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 4,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] amt_reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [1:0]       src_i,
    output logic [AMT_W-1:0] amt_o
);
    import shf_pkg::*;
    localparam int IMM_OFS = 2 ** IMM_W;

    shf_src_e src;
    assign src = shf_src_e'(src_i);

    always_comb begin
        unique case (src)
            SHS_IMM:  amt_o = AMT_W'(imm_i);
            SHS_IMMH: amt_o = AMT_W'(imm_i) + AMT_W'(IMM_OFS);
            default:  amt_o = amt_reg_i[AMT_W-1:0];
        endcase
    end
endmodule

// File: rtl/shf_core.sv
module shf_core #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [1:0]       kind_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_o
);
    import shf_pkg::*;

    shf_kind_e kind;
    assign kind = shf_kind_e'(kind_i);

    // Left: a guard bit above the operand catches the last bit out.
    // Right: a guard bit below the operand catches the last bit out.
    logic        [WIDTH:0] left_x;
    logic        [WIDTH:0] lsr_x;
    logic signed [WIDTH:0] asr_in;
    logic signed [WIDTH:0] asr_x;

    always_comb begin
        left_x = {1'b0, opnd_i} << amt_i;
        lsr_x  = {opnd_i, 1'b0} >> amt_i;
        asr_in = {opnd_i, 1'b0};
        asr_x  = asr_in >>> amt_i;
    end

    always_comb begin
        unique case (kind)
            SHK_LSR: begin
                res_o = lsr_x[WIDTH:1];
                c_o   = lsr_x[0];
            end
            SHK_ASR: begin
                res_o = asr_x[WIDTH:1];
                c_o   = asr_x[0];
            end
            default: begin
                res_o = left_x[WIDTH-1:0];
                c_o   = left_x[WIDTH];
            end
        endcase
    end
endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    output logic             n_o,
    output logic             z_o
);
    always_comb begin
        n_o = res_i[WIDTH-1];
        z_o = ~|res_i;
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 4,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [WIDTH-1:0] amt_reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [1:0]       kind_i,
    input  logic [1:0]       src_i,
    input  logic             v_i,
    output logic [WIDTH-1:0] res_o,
    output logic             n_o,
    output logic             z_o,
    output logic             v_o,
    output logic             c_o
);
    logic [AMT_W-1:0] amt;
    logic [WIDTH-1:0] res_d;
    logic             c_d;
    logic             n_d;
    logic             z_d;

    shf_amt_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_amt (
        .amt_reg_i (amt_reg_i),
        .imm_i     (imm_i),
        .src_i     (src_i),
        .amt_o     (amt)
    );

    shf_core #(.WIDTH(WIDTH)) u_core (
        .opnd_i (opnd_i),
        .amt_i  (amt),
        .kind_i (kind_i),
        .res_o  (res_d),
        .c_o    (c_d)
    );

    shf_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i (res_d),
        .n_o   (n_d),
        .z_o   (z_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o <= '0;
            n_o   <= 1'b0;
            z_o   <= 1'b0;
            v_o   <= 1'b0;
            c_o   <= 1'b0;
        end else begin
            res_o <= res_d;
            n_o   <= n_d;
            z_o   <= z_d;
            v_o   <= v_i;
            c_o   <= c_d;
        end
    end

    AST_V_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> v_o == $past(v_i));                                          // R9
    AST_N_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        n_o == res_o[WIDTH-1]);                                               // R8
    AST_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == 2'b01 && imm_i == '0) |=> res_o == $past(opnd_i) && !c_o);  // R7
    AST_ASR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        kind_i == 2'b10 |=> res_o[WIDTH-1] == $past(opnd_i[WIDTH-1]));       // R3
    AST_LSR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 2'b01 && src_i == 2'b10) |=> res_o[WIDTH-1:WIDTH/2] == '0); // R6
    AST_LSL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 2'b00 && src_i == 2'b10) |=> res_o[WIDTH/2-1:0] == '0);   // R1
endmodule

// File: tb/shf_unit_tb.sv
module shf_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_i = '0;
    logic [31:0] amt_reg_i = '0;
    logic [3:0]  imm_i = '0;
    logic [1:0]  kind_i = '0;
    logic [1:0]  src_i = '0;
    logic        v_i = 1'b0;
    logic [31:0] res_o;
    logic        n_o, z_o, v_o, c_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shf_unit u_dut (
        .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .amt_reg_i(amt_reg_i),
        .imm_i(imm_i), .kind_i(kind_i), .src_i(src_i), .v_i(v_i),
        .res_o(res_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Bit-serial reference model.
    int          m_amt;
    logic [31:0] m_res;
    logic        m_c;

    task automatic model(input logic [31:0] op, input logic [31:0] ar, input logic [3:0] im,
                         input logic [1:0] kd, input logic [1:0] sr);
        if (sr == 2'b01)      m_amt = int'(im);
        else if (sr == 2'b10) m_amt = int'(im) + 16;
        else                  m_amt = int'(ar % 32);
        m_res = op;
        m_c = 1'b0;
        for (int i = 0; i < m_amt; i++) begin
            if (kd == 2'b01) begin
                m_c = m_res[0];
                m_res = {1'b0, m_res[31:1]};
            end else if (kd == 2'b10) begin
                m_c = m_res[0];
                m_res = {m_res[31], m_res[31:1]};
            end else begin
                m_c = m_res[31];
                m_res = {m_res[30:0], 1'b0};
            end
        end
    endtask

    // Drive on a falling edge, let one rising edge register, compare at the next falling edge.
    task automatic run(input logic [31:0] op, input logic [31:0] ar, input logic [3:0] im,
                       input logic [1:0] kd, input logic [1:0] sr, input logic vv,
                       input string tag);
        opnd_i = op; amt_reg_i = ar; imm_i = im; kind_i = kd; src_i = sr; v_i = vv;
        model(op, ar, im, kd, sr);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " result"}, res_o, m_res);
        chk("R7 carry", 32'(c_o), 32'(m_c));
        chk("R8 negative", 32'(n_o), 32'(m_res[31]));
        chk("R8 zero", 32'(z_o), 32'(m_res == 32'h0));
        chk("R9 overflow", 32'(v_o), 32'(vv));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        opnd_i = 32'hFFFF_FFFF; v_i = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset result", res_o, 32'h0);
        chk("R10 reset flags", {28'h0, n_o, z_o, v_o, c_o}, 32'h0);
        rst_n = 1'b1;

        // R1 left
        run(32'h8000_0001, 32'd1, 4'd0, 2'b00, 2'b00, 1'b0, "R1 lsl reg 1");
        run(32'h1234_5678, 32'd0, 4'd4, 2'b00, 2'b01, 1'b1, "R1 lsl imm 4");
        // R2 logical right
        run(32'h8000_0003, 32'd0, 4'd1, 2'b01, 2'b01, 1'b0, "R2 lsr imm 1");
        run(32'hF000_0000, 32'd31, 4'd0, 2'b01, 2'b00, 1'b1, "R2 lsr reg 31");
        // R3 arithmetic right, and alternate left code
        run(32'h8000_0000, 32'd0, 4'd15, 2'b10, 2'b10, 1'b0, "R3 asr imm+16 31");
        run(32'h7000_0001, 32'd0, 4'd3, 2'b10, 2'b01, 1'b0, "R3 asr positive");
        run(32'h0000_00F1, 32'd8, 4'd0, 2'b11, 2'b00, 1'b1, "R3 code 11 as left");
        // R4 upper register bits ignored, alternate register code
        run(32'hDEAD_BEEF, 32'hFFFF_FFE3, 4'd9, 2'b01, 2'b00, 1'b0, "R4 reg high bits");
        run(32'hDEAD_BEEF, 32'h0000_0025, 4'd9, 2'b00, 2'b11, 1'b0, "R4 src 11 reg");
        // R5 immediate range ends
        run(32'hCAFE_F00D, 32'd7, 4'd15, 2'b00, 2'b01, 1'b0, "R5 imm 15");
        // R6 offset immediate
        run(32'hCAFE_F00D, 32'd7, 4'd0, 2'b01, 2'b10, 1'b0, "R6 imm+16 16");
        run(32'h8765_4321, 32'd7, 4'd15, 2'b00, 2'b10, 1'b1, "R6 lsl 31");
        // R7 zero amount
        run(32'hFFFF_FFFF, 32'h0000_0020, 4'd0, 2'b10, 2'b00, 1'b0, "R7 zero amt reg");
        run(32'h8000_0001, 32'd0, 4'd0, 2'b00, 2'b01, 1'b1, "R7 zero amt imm");
        // R8 zero result
        run(32'h0000_0001, 32'd0, 4'd1, 2'b01, 2'b01, 1'b0, "R8 zero result");
        // Mixed patterns
        for (int k = 0; k < 400; k++) begin
            run($urandom, $urandom, 4'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
                "R1 R2 R3 mixed");
        end
        // R10: back-to-back latency after reset re-entry
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10 reset result again", res_o, 32'h0);
        rst_n = 1'b1;
        run(32'h0000_8000, 32'd0, 4'd15, 2'b01, 2'b01, 1'b1, "R10 first after reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule